// File: doc/BRIEF.md
# External Trigger One-Shot Timer

This block measures a fixed delay that is launched by an edge on an asynchronous trigger pin. Once the chosen edge is seen, a 16-bit up-counter advances on a count clock derived from the system clock by a power-of-two division. When the count equals a programmed compare value, the counter clears and stops, and a single-cycle interrupt pulse is produced. The counter then waits for the next trigger edge.

A mode input selects how the edge opposite to the trigger edge is treated. In start-only mode it is ignored, as is any new trigger edge while a count is in progress. In start-and-stop mode it clears and stops the counter without an interrupt. An interrupt therefore signals that the active level of a pulse lasted longer than the programmed width. The trigger pin passes through a two-flop synchronizer and a level filter, so short glitches do not start the counter.

Top module: `trig_oneshot_timer`

## Requirements
- R1: While reset is asserted and after it is released with no trigger activity, `irqPulse` stays low.
- R2: `edgeSel`=0 makes a rising edge of `trigAsync` the start edge, and `edgeSel`=1 makes a falling edge the start edge. The edge of the other polarity never starts a count.
- R3: The counter advances once every 2^`prescSel` system clocks. When the count equals `compareVal`, the counter clears and stops. With a clean trigger transition first sampled at clock edge 1, `irqPulse` rises at clock edge 11 + (`compareVal`+1)·2^`prescSel`.
- R4: A `compareVal` of zero produces the match on the first count-clock tick after the start.
- R5: `irqPulse` is high for exactly one system-clock cycle per match.
- R6: With `stopMode`=1, an opposite edge that arrives before the match clears and stops the counter, and no interrupt follows.
- R7: With `stopMode`=0, an opposite edge during a count leaves the interrupt timing unchanged.
- R8: With `stopMode`=0, a new start edge during a count is ignored. The interrupt comes at the time set by the first edge, and no second interrupt follows.
- R9: After a match, the next start edge restarts the count from zero with the same latency.
- R10: A trigger level that lasts 4 system clocks or less is rejected. A level that lasts 12 system clocks or more is accepted as an edge.
- R11: Driving `enable` low clears and stops a running count at once. A start edge seen while `enable` is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigAsync | input | 1 | Asynchronous external trigger pin |
| edgeSel | input | 1 | Start edge: 0 rising, 1 falling |
| stopMode | input | 1 | 1: opposite edge aborts the count; 0: start only |
| enable | input | 1 | Timer enable; low clears and halts |
| prescSel | input | 4 | Count clock = system clock / 2^prescSel |
| compareVal | input | 16 | Compare value for the match |
| irqPulse | output | 1 | One-cycle interrupt pulse on a match |

## Verification
The main delay is tried with both start polarities, several prescaler settings and several compare values, including zero. Each case checks the exact cycle in which the interrupt appears, which separates off-by-one errors in the prescaler from those in the compare. The pulse is then reshaped: it returns early, it is retriggered, or it is too short. These cases tell start-only handling apart from start-and-stop handling and show the filter threshold. Enable toggling during a run and before a start shows that the abort is immediate and that a start seen while disabled is not kept.

// File: rtl/tot_pkg.sv
package tot_pkg;
  typedef struct packed {
    logic clearAll;
    logic countEn;
  } tot_strobe_t;
endpackage

// File: rtl/tot_datapath.sv
module tot_datapath
  import tot_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 4,
  parameter int FILT_LEN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigAsync,
  input  logic             edgeSel,
  input  logic [SEL_W-1:0] prescSel,
  input  logic [CNT_W-1:0] compareVal,
  input  tot_strobe_t      strobes,
  output logic             trigEdge,
  output logic             oppEdge,
  output logic             matchHit
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam int FC_W  = $clog2(FILT_LEN + 1);

  logic syncA, syncLvl;
  logic filtLevel, prevFilt;
  logic [FC_W-1:0] filtCnt;
  logic [PRE_W-1:0] preDiv, preMask;
  logic [CNT_W-1:0] cnt;
  logic tick, anyEdge;

  // two-flop synchronizer
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      syncA   <= 1'b0;
      syncLvl <= 1'b0;
    end else begin
      syncA   <= trigAsync;
      syncLvl <= syncA;
    end

  // level filter: accept a new level after FILT_LEN differing cycles
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      filtLevel <= 1'b0;
      filtCnt   <= '0;
      prevFilt  <= 1'b0;
    end else begin
      prevFilt <= filtLevel;
      if (syncLvl == filtLevel) filtCnt <= '0;
      else if (filtCnt == FC_W'(FILT_LEN - 1)) begin
        filtLevel <= syncLvl;
        filtCnt   <= '0;
      end else filtCnt <= filtCnt + 1'b1;
    end

  assign anyEdge  = filtLevel != prevFilt;
  assign trigEdge = anyEdge && (filtLevel != edgeSel);
  assign oppEdge  = anyEdge && (filtLevel == edgeSel);

  // prescaler restarted on every clear
  assign preMask = (PRE_W'(1) << prescSel) - PRE_W'(1);
  assign tick    = (preDiv & preMask) == preMask;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) preDiv <= '0;
    else if (strobes.clearAll) preDiv <= '0;
    else preDiv <= preDiv + 1'b1;

  assign matchHit = strobes.countEn && tick && (cnt == compareVal);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) cnt <= '0;
    else if (strobes.clearAll) cnt <= '0;
    else if (strobes.countEn && tick && !matchHit) cnt <= cnt + 1'b1;

  // R3: count only moves on a count-clock tick or a clear
  assert_tick_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobes.clearAll) |=> $stable(cnt));

  // R10: filtered level holds while the synchronized input agrees with it
  assert_filter_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (syncLvl == filtLevel) |=> $stable(filtLevel));
endmodule

// File: rtl/tot_control.sv
module tot_control
  import tot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        stopMode,
  input  logic        trigEdge,
  input  logic        oppEdge,
  input  logic        matchHit,
  output tot_strobe_t strobes,
  output logic        irqPulse
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state, nextState;
  logic fireIrq;

  always_comb begin
    nextState = state;
    fireIrq   = 1'b0;
    unique case (state)
      ST_IDLE: if (enable && trigEdge) nextState = ST_RUN;
      ST_RUN: begin
        if (!enable) nextState = ST_IDLE;
        else if (stopMode && oppEdge) nextState = ST_IDLE;
        else if (matchHit) begin
          nextState = ST_IDLE;
          fireIrq   = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign strobes.countEn  = (state == ST_RUN);
  assign strobes.clearAll = (state == ST_IDLE) || (nextState == ST_IDLE);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state    <= ST_IDLE;
      irqPulse <= 1'b0;
    end else begin
      state    <= nextState;
      irqPulse <= fireIrq;
    end

  // R5: interrupt is a single cycle wide
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R11: a low enable leaves the timer halted
  assert_disable_halts_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_IDLE));

  // R6: abort in start-and-stop mode is silent
  assert_abort_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && enable && stopMode && oppEdge) |=> (!irqPulse && state == ST_IDLE));

  // R8: while running without an end event, the run continues
  assert_ignore_retrig_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && enable && !matchHit && !(stopMode && oppEdge)) |=> (state == ST_RUN));
endmodule

// File: rtl/trig_oneshot_timer.sv
module trig_oneshot_timer
  import tot_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 4,
  parameter int FILT_LEN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigAsync,
  input  logic             edgeSel,
  input  logic             stopMode,
  input  logic             enable,
  input  logic [SEL_W-1:0] prescSel,
  input  logic [CNT_W-1:0] compareVal,
  output logic             irqPulse
);
  tot_strobe_t strobes;
  logic trigEdge, oppEdge, matchHit;

  tot_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W), .FILT_LEN(FILT_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .trigAsync(trigAsync), .edgeSel(edgeSel),
    .prescSel(prescSel), .compareVal(compareVal), .strobes(strobes),
    .trigEdge(trigEdge), .oppEdge(oppEdge), .matchHit(matchHit)
  );

  tot_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .stopMode(stopMode),
    .trigEdge(trigEdge), .oppEdge(oppEdge), .matchHit(matchHit),
    .strobes(strobes), .irqPulse(irqPulse)
  );
endmodule

// File: tb/trig_oneshot_timer_test.sv
module trig_oneshot_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigAsync = 1'b0;
  logic edgeSel = 1'b0;
  logic stopMode = 1'b0;
  logic enable = 1'b0;
  logic [3:0] prescSel = '0;
  logic [15:0] compareVal = '0;
  logic irqPulse;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  trig_oneshot_timer uut (
    .clk(clk), .rstN(rstN), .trigAsync(trigAsync), .edgeSel(edgeSel),
    .stopMode(stopMode), .enable(enable), .prescSel(prescSel),
    .compareVal(compareVal), .irqPulse(irqPulse)
  );

  // vector: edgeSel, prescSel, compareVal, expected irq cycle
  typedef struct packed {
    logic        pol;
    logic [3:0]  sel;
    logic [15:0] cmp;
    logic [15:0] expCyc;
  } vec_t;
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'd0, 16'd0,  16'd12},
    '{1'b0, 4'd0, 16'd5,  16'd17},
    '{1'b0, 4'd2, 16'd3,  16'd27},
    '{1'b1, 4'd1, 16'd4,  16'd21},
    '{1'b1, 4'd3, 16'd2,  16'd35},
    '{1'b0, 4'd0, 16'd20, 16'd32}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts negedges until irqPulse is seen; 0 when none within limit
  task automatic waitIrq(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (irqPulse) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic setIdle(input logic pol, input logic sm, input logic [3:0] s, input logic [15:0] c);
    @(negedge clk);
    enable = 1'b0;
    edgeSel = pol;
    stopMode = sm;
    prescSel = s;
    compareVal = c;
    trigAsync = pol;
    repeat (25) @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    int m;
    int sawHigh;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(irqPulse == 1'b0, "R1 irq during reset", irqPulse, 0);
    rstN = 1'b1;
    sawHigh = 0;
    repeat (30) begin
      @(negedge clk);
      if (irqPulse) sawHigh = 1;
    end
    check(sawHigh == 0, "R1 irq idle after reset", sawHigh, 0);

    // R2 R3 R4 R9: vector table, start-only mode
    foreach (VECS[i]) begin
      setIdle(VECS[i].pol, 1'b0, VECS[i].sel, VECS[i].cmp);
      trigAsync = ~VECS[i].pol;
      waitIrq(2000, n);
      check(n == int'(VECS[i].expCyc), "R2 R3 R4 R9 irq latency", n, int'(VECS[i].expCyc));
      @(negedge clk);
      check(irqPulse == 1'b0, "R5 irq one cycle", irqPulse, 0);
      trigAsync = VECS[i].pol;
    end

    // R9: back-to-back restart without reconfiguring
    setIdle(1'b0, 1'b0, 4'd0, 16'd7);
    trigAsync = 1'b1;
    waitIrq(500, n);
    trigAsync = 1'b0;
    repeat (30) @(negedge clk);
    trigAsync = 1'b1;
    waitIrq(500, m);
    check(m == 19 && n == 19, "R9 restart latency", m, 19);

    // R2: opposite polarity alone never starts (falling-edge mode, rising input)
    setIdle(1'b1, 1'b0, 4'd0, 16'd0);
    trigAsync = 1'b0;
    repeat (30) @(negedge clk);
    trigAsync = 1'b1;  // rising edge in falling mode: must not start
    waitIrq(100, n);
    check(n == 0, "R2 wrong polarity ignored", n, 0);

    // R10: 4-cycle glitch rejected
    setIdle(1'b0, 1'b0, 4'd0, 16'd0);
    trigAsync = 1'b1;
    repeat (4) @(negedge clk);
    trigAsync = 1'b0;
    waitIrq(200, n);
    check(n == 0, "R10 short pulse rejected", n, 0);

    // R10: 12-cycle pulse accepted
    setIdle(1'b0, 1'b0, 4'd0, 16'd0);
    fork
      begin trigAsync = 1'b1; repeat (12) @(negedge clk); trigAsync = 1'b0; end
      waitIrq(200, n);
    join
    check(n == 12, "R10 long pulse accepted", n, 12);

    // R6: stop mode, early opposite edge aborts silently
    setIdle(1'b0, 1'b1, 4'd0, 16'd50);
    fork
      begin trigAsync = 1'b1; repeat (20) @(negedge clk); trigAsync = 1'b0; end
      waitIrq(200, n);
    join
    check(n == 0, "R6 abort no irq", n, 0);

    // R6: stop mode, pulse longer than width raises irq
    setIdle(1'b0, 1'b1, 4'd0, 16'd50);
    trigAsync = 1'b1;
    waitIrq(200, n);
    check(n == 62, "R6 long pulse irq", n, 62);
    trigAsync = 1'b0;

    // R7: start-only, opposite edge has no effect
    setIdle(1'b0, 1'b0, 4'd0, 16'd50);
    fork
      begin trigAsync = 1'b1; repeat (20) @(negedge clk); trigAsync = 1'b0; end
      waitIrq(200, n);
    join
    check(n == 62, "R7 opposite edge ignored", n, 62);

    // R8: start-only, retrigger ignored
    setIdle(1'b0, 1'b0, 4'd0, 16'd60);
    fork
      begin
        trigAsync = 1'b1; repeat (20) @(negedge clk);
        trigAsync = 1'b0; repeat (20) @(negedge clk);
        trigAsync = 1'b1;
      end
      waitIrq(300, n);
    join
    check(n == 72, "R8 retrigger ignored timing", n, 72);
    waitIrq(150, m);
    check(m == 0, "R8 no second irq", m, 0);
    trigAsync = 1'b0;

    // R11: enable drop mid-count aborts
    setIdle(1'b0, 1'b0, 4'd0, 16'd50);
    fork
      begin
        trigAsync = 1'b1; repeat (30) @(negedge clk);
        enable = 1'b0; @(negedge clk); enable = 1'b1;
      end
      waitIrq(200, n);
    join
    check(n == 0, "R11 disable aborts", n, 0);
    trigAsync = 1'b0;

    // R11: start edge while disabled is dropped
    setIdle(1'b0, 1'b0, 4'd0, 16'd0);
    enable = 1'b0;
    trigAsync = 1'b1;
    repeat (30) @(negedge clk);
    enable = 1'b1;
    waitIrq(200, n);
    check(n == 0, "R11 pending start dropped", n, 0);
    trigAsync = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule